// File: doc/BRIEF.md
# Cursor Overlay Pixel Stage

This stage sits in a display datapath after the frame-store fetch. Each cycle it may accept one 8-bit colour index together with the raster column and line of that pixel. One clock later it presents one 24-bit RGB value. The stage reads the background colour from a 256-entry colour store through a simple read port.

A 64×64 pointer window is placed at a programmable origin. For pixels inside that window, a 2-bit pattern code replaces the background colour with one of three pointer colours. The pattern code comes from a 16-bit pattern store that packs eight codes per word. A code of zero lets the background show through.

Two control inputs change the output. The first disables the pointer, so every pixel takes its background colour. The second blanks the screen, so every pixel is black. All three stores are read combinationally, so their data is expected back in the same cycle as the address.

Top module: `cursor_overlay_pipe`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock edge. While reset is held, `out_valid` is 0 and `out_rgb` is 0.
- R2: A pixel outside the pointer window produces the colour-store entry addressed by its index. The colour store is read with `pal_rd_addr` equal to `in_index`.
- R3: The pointer origin is taken from `cur_pos`. The column is `cur_pos[23:12]` and the line is `cur_pos[11:0]`. A pixel is inside the window when xcur ≤ x ≤ xcur+63 and ycur ≤ y ≤ ycur+63.
- R4: Inside the window, the pattern word is read at address (y−ycur)×8 + (x−xcur)/8.
- R5: The code for a pixel is bits [2k+1:2k] of its pattern word, where k = (x−xcur) mod 8. The leftmost pixel of a word therefore uses bits [1:0].
- R6: Code 0 produces the colour-store entry of the pixel's index. Codes 1, 2 and 3 produce pointer colours 0, 1 and 2, read with `cpal_rd_addr` equal to the code minus one.
- R7: When `ctl_cursor_off` is 1, no pixel is inside the window, and every pixel produces its colour-store entry.
- R8: When `ctl_blank` is 1, the output pixel is 24'h000000. This takes precedence over the pointer and the colour store.
- R9: The window never wraps past the edge of the coordinate range. With an origin near 4095 on either axis, pixels at small coordinates stay outside, while pixels from the origin up to 4095 are still inside.
- R10: A cycle with `in_valid` low leaves `out_rgb` unchanged on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_index | input | 8 | Colour index of the input pixel |
| in_x | input | 12 | Raster column of the input pixel |
| in_y | input | 12 | Raster line of the input pixel |
| cur_pos | input | 24 | Pointer origin: column in [23:12], line in [11:0] |
| ctl_blank | input | 1 | Force every output pixel to black |
| ctl_cursor_off | input | 1 | Disable the pointer window |
| pal_rd_addr | output | 8 | Colour-store read address |
| pal_rd_data | input | 24 | Colour-store read data, same cycle |
| pat_rd_addr | output | 9 | Pattern-store word address |
| pat_rd_data | input | 16 | Pattern-store word, same cycle |
| cpal_rd_addr | output | 2 | Pointer-colour read address |
| cpal_rd_data | input | 24 | Pointer-colour read data, same cycle |
| out_valid | output | 1 | Output pixel present |
| out_rgb | output | 24 | Output colour, {R,G,B} |

## Verification
The stage has one register stage, so every colour result and every valid flag is due exactly one rising edge after the edge that samples the input. The bench drives each pixel on the falling edge. It then reads `out_rgb` and `out_valid` a quarter period after the next rising edge, so each check sees exactly the response to the previous stimulus.

For the hold check, the bench presents a pixel with `in_valid` low and a different index. It then reads the output one edge later and compares it with the value left by the last valid pixel. The reset state is read while `rst_n` is still low, after one rising edge.

// File: rtl/cursor_overlay_pkg.sv
// Shared types for the cursor overlay stage.
// Assumes 8-bit colour channels packed as {R,G,B}.
package cursor_overlay_pkg;
    localparam int CHAN_W = 8;
    localparam int RGB_W  = 3 * CHAN_W;

    typedef logic [RGB_W-1:0] rgb_t;

    // Pattern code meanings; code 0 lets the background through
    typedef enum logic [1:0] {
        CODE_CLEAR = 2'd0,
        CODE_COL0  = 2'd1,
        CODE_COL1  = 2'd2,
        CODE_COL2  = 2'd3
    } cur_code_e;
endpackage

// File: rtl/cursor_window_hit.sv
// Decides whether a pixel falls in the square pointer window.
// It also yields the pattern word address and the pixel slot within that word.
// Assumes CUR_SIZE and PIX_PER_WORD are powers of two.
// Differences are taken one bit wider than the coordinates, so the window never wraps.
module cursor_window_hit #(
    parameter int COORD_W      = 12,
    parameter int CUR_SIZE     = 64,
    parameter int PIX_PER_WORD = 8,
    localparam int OFF_W       = $clog2(CUR_SIZE),
    localparam int SUB_W       = $clog2(PIX_PER_WORD),
    localparam int COL_W       = OFF_W - SUB_W,
    localparam int AW          = OFF_W + COL_W
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [COORD_W-1:0] xcur,
    input  logic [COORD_W-1:0] ycur,
    input  logic               enable,
    output logic               hit,
    output logic [AW-1:0]      word_addr,
    output logic [SUB_W-1:0]   slot
);
    logic [COORD_W:0] dx;
    logic [COORD_W:0] dy;
    logic             in_x;
    logic             in_y;

    // Signed-by-borrow offsets from the origin and the window test
    always_comb begin
        dx   = {1'b0, x} - {1'b0, xcur};
        dy   = {1'b0, y} - {1'b0, ycur};
        in_x = !dx[COORD_W] && (dx[COORD_W-1:0] < COORD_W'(CUR_SIZE));
        in_y = !dy[COORD_W] && (dy[COORD_W-1:0] < COORD_W'(CUR_SIZE));
        hit  = enable && in_x && in_y;
        word_addr = {dy[OFF_W-1:0], dx[OFF_W-1:SUB_W]};
        slot      = dx[SUB_W-1:0];
    end
endmodule

// File: rtl/cursor_code_pick.sv
// Selects one packed code from a pattern word.
// Slot 0 sits in the least significant bits.
module cursor_code_pick #(
    parameter int CODE_W       = 2,
    parameter int PIX_PER_WORD = 8,
    localparam int WORD_W      = CODE_W * PIX_PER_WORD,
    localparam int SUB_W       = $clog2(PIX_PER_WORD)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SUB_W-1:0]  slot,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] codes [PIX_PER_WORD];

    for (genvar g = 0; g < PIX_PER_WORD; g++) begin : g_slot
        // Unpack slot g from the word
        assign codes[g] = word[g*CODE_W +: CODE_W];
    end

    // Choose the slot for the current pixel
    always_comb code = codes[slot];
endmodule

// File: rtl/overlay_colour_reg.sv
// Final colour choice and the single output register.
// Blank has priority over the pointer, and the pointer over the background.
// out_rgb only loads on valid input cycles.
module overlay_colour_reg
    import cursor_overlay_pkg::*;
#(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              blank,
    input  logic              hit,
    input  logic [CODE_W-1:0] code,
    input  rgb_t              bg_rgb,
    input  rgb_t              cur_rgb,
    output logic              out_valid,
    output rgb_t              out_rgb
);
    rgb_t next_rgb;

    // Priority mux between black, pointer colour and background
    always_comb begin
        if (blank)                next_rgb = '0;
        else if (hit && code != '0) next_rgb = cur_rgb;
        else                      next_rgb = bg_rgb;
    end

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_rgb <= next_rgb;
        end
    end
endmodule

// File: rtl/cursor_overlay_pipe.sv
// Top of the cursor overlay stage.
// Reads the colour, pattern and pointer-colour stores combinationally,
// then registers one RGB pixel per valid input.
// Assumes all store read data returns in the cycle its address is presented.
module cursor_overlay_pipe
    import cursor_overlay_pkg::*;
#(
    parameter int COORD_W      = 12,
    parameter int IDX_W        = 8,
    parameter int CUR_SIZE     = 64,
    parameter int PIX_PER_WORD = 8,
    parameter int CODE_W       = 2,
    localparam int WORD_W      = CODE_W * PIX_PER_WORD,
    localparam int OFF_W       = $clog2(CUR_SIZE),
    localparam int SUB_W       = $clog2(PIX_PER_WORD),
    localparam int PAT_AW      = 2 * OFF_W - SUB_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [IDX_W-1:0]     in_index,
    input  logic [COORD_W-1:0]   in_x,
    input  logic [COORD_W-1:0]   in_y,
    input  logic [2*COORD_W-1:0] cur_pos,
    input  logic                 ctl_blank,
    input  logic                 ctl_cursor_off,
    output logic [IDX_W-1:0]     pal_rd_addr,
    input  logic [RGB_W-1:0]     pal_rd_data,
    output logic [PAT_AW-1:0]    pat_rd_addr,
    input  logic [WORD_W-1:0]    pat_rd_data,
    output logic [CODE_W-1:0]    cpal_rd_addr,
    input  logic [RGB_W-1:0]     cpal_rd_data,
    output logic                 out_valid,
    output logic [RGB_W-1:0]     out_rgb
);
    logic               hit;
    logic [SUB_W-1:0]   slot;
    logic [CODE_W-1:0]  code;

    cursor_window_hit #(
        .COORD_W(COORD_W), .CUR_SIZE(CUR_SIZE), .PIX_PER_WORD(PIX_PER_WORD)
    ) u_win (
        .x(in_x), .y(in_y),
        .xcur(cur_pos[2*COORD_W-1:COORD_W]), .ycur(cur_pos[COORD_W-1:0]),
        .enable(!ctl_cursor_off),
        .hit(hit), .word_addr(pat_rd_addr), .slot(slot)
    );

    cursor_code_pick #(
        .CODE_W(CODE_W), .PIX_PER_WORD(PIX_PER_WORD)
    ) u_pick (
        .word(pat_rd_data), .slot(slot), .code(code)
    );

    // Store addresses: background by index, pointer colour by code minus one
    always_comb begin
        pal_rd_addr  = in_index;
        cpal_rd_addr = (code == '0) ? '0 : code - CODE_W'(1);
    end

    overlay_colour_reg #(
        .CODE_W(CODE_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .blank(ctl_blank),
        .hit(hit), .code(code), .bg_rgb(pal_rd_data), .cur_rgb(cpal_rd_data),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );
endmodule

// File: rtl/cursor_overlay_checker.sv
// Temporal properties of the cursor overlay stage, attached by bind.
// Watches only top-level ports.
module cursor_overlay_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        ctl_blank,
    input logic        ctl_cursor_off,
    input logic [23:0] pal_rd_data,
    input logic        out_valid,
    input logic [23:0] out_rgb
);
    // R1
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl_blank) |=> (out_rgb == 24'h0));

    // R7
    cursor_off_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ctl_blank && ctl_cursor_off) |=> (out_rgb == $past(pal_rd_data)));

    // R10
    hold_rgb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_rgb));
endmodule

bind cursor_overlay_pipe cursor_overlay_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctl_blank(ctl_blank),
    .ctl_cursor_off(ctl_cursor_off), .pal_rd_data(pal_rd_data),
    .out_valid(out_valid), .out_rgb(out_rgb)
);

// File: tb/test_cursor_overlay_pipe.sv
module test_cursor_overlay_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_index = '0;
    logic [11:0] in_x = '0;
    logic [11:0] in_y = '0;
    logic [23:0] cur_pos = '0;
    logic        ctl_blank = 1'b0;
    logic        ctl_cursor_off = 1'b0;
    logic [7:0]  pal_rd_addr;
    logic [23:0] pal_rd_data;
    logic [8:0]  pat_rd_addr;
    logic [15:0] pat_rd_data;
    logic [1:0]  cpal_rd_addr;
    logic [23:0] cpal_rd_data;
    logic        out_valid;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // Bench-side stores
    logic [23:0] pal_mem [256];
    logic [15:0] pat_mem [512];
    logic [23:0] cpal_mem [4];
    assign pal_rd_data  = pal_mem[pal_rd_addr];
    assign pat_rd_data  = pat_mem[pat_rd_addr];
    assign cpal_rd_data = cpal_mem[cpal_rd_addr];

    cursor_overlay_pipe i_cursor_overlay_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_index(in_index),
        .in_x(in_x), .in_y(in_y), .cur_pos(cur_pos), .ctl_blank(ctl_blank),
        .ctl_cursor_off(ctl_cursor_off), .pal_rd_addr(pal_rd_addr),
        .pal_rd_data(pal_rd_data), .pat_rd_addr(pat_rd_addr),
        .pat_rd_data(pat_rd_data), .cpal_rd_addr(cpal_rd_addr),
        .cpal_rd_data(cpal_rd_data), .out_valid(out_valid), .out_rgb(out_rgb)
    );

    // src: 0 background, 1..3 pointer colour 0..2, 4 black
    typedef struct packed {
        logic [11:0] x;
        logic [11:0] y;
        logic [7:0]  idx;
        logic [23:0] pos;
        logic        blank;
        logic        off;
        logic [2:0]  src;
    } vec_t;

    localparam logic [23:0] P0 = {12'd100, 12'd50};
    localparam logic [23:0] PX = {12'd4090, 12'd50};
    localparam logic [23:0] PY = {12'd100, 12'd4090};

    localparam vec_t VECS [17] = '{
        '{12'd100, 12'd50,  8'd7,   P0, 1'b0, 1'b0, 3'd1},  // R3 R5 origin, slot 0 code 1
        '{12'd101, 12'd50,  8'd7,   P0, 1'b0, 1'b0, 3'd2},  // R5 slot 1 code 2
        '{12'd102, 12'd50,  8'd7,   P0, 1'b0, 1'b0, 3'd3},  // R5 slot 2 code 3
        '{12'd103, 12'd50,  8'd9,   P0, 1'b0, 1'b0, 3'd0},  // R6 code 0
        '{12'd99,  12'd50,  8'd11,  P0, 1'b0, 1'b0, 3'd0},  // R2 left of window
        '{12'd163, 12'd113, 8'd12,  P0, 1'b0, 1'b0, 3'd3},  // R4 last corner
        '{12'd164, 12'd113, 8'd13,  P0, 1'b0, 1'b0, 3'd0},  // R3 right edge
        '{12'd163, 12'd114, 8'd14,  P0, 1'b0, 1'b0, 3'd0},  // R3 bottom edge
        '{12'd100, 12'd49,  8'd15,  P0, 1'b0, 1'b0, 3'd0},  // R3 above
        '{12'd120, 12'd55,  8'd16,  P0, 1'b0, 1'b0, 3'd2},  // R4 word 42 slot 4
        '{12'd100, 12'd50,  8'd17,  P0, 1'b0, 1'b1, 3'd0},  // R7
        '{12'd100, 12'd50,  8'd18,  P0, 1'b1, 1'b0, 3'd4},  // R8 over pointer
        '{12'd5,   12'd5,   8'd200, P0, 1'b1, 1'b0, 3'd4},  // R8 background
        '{12'd2,   12'd50,  8'd3,   PX, 1'b0, 1'b0, 3'd0},  // R9 x wrap
        '{12'd100, 12'd2,   8'd4,   PY, 1'b0, 1'b0, 3'd0},  // R9 y wrap
        '{12'd4090,12'd50,  8'd5,   PX, 1'b0, 1'b0, 3'd1},  // R9 origin near edge
        '{12'd200, 12'd300, 8'd255, P0, 1'b0, 1'b0, 3'd0}   // R2
    };

    function automatic logic [23:0] expect_rgb(input logic [2:0] src, input logic [7:0] idx);
        if (src == 3'd4)      return 24'h0;
        else if (src == 3'd0) return pal_mem[idx];
        else                  return cpal_mem[src - 3'd1];
    endfunction

    task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [11:0] x, input logic [11:0] y,
                         input logic [7:0] idx, input logic [23:0] pos,
                         input logic bl, input logic off);
        @(negedge clk);
        in_valid = v; in_x = x; in_y = y; in_index = idx;
        cur_pos = pos; ctl_blank = bl; ctl_cursor_off = off;
        @(posedge clk);
        #5;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual %h expected %h", 24'h0, 24'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] held;
        for (int i = 0; i < 256; i++) pal_mem[i] = {i[7:0], ~i[7:0], i[7:0] ^ 8'h5A};
        for (int i = 0; i < 512; i++) pat_mem[i] = 16'h0;
        pat_mem[0]   = 16'h0039;  // slots 0..2 codes 1,2,3
        pat_mem[1]   = 16'hFFFF;  // trap for x wrap
        pat_mem[64]  = 16'hFFFF;  // trap for y wrap
        pat_mem[42]  = 16'h0200;  // slot 4 code 2
        pat_mem[511] = 16'hC000;  // slot 7 code 3
        cpal_mem[0] = 24'hFF0000; cpal_mem[1] = 24'h00FF00;
        cpal_mem[2] = 24'h0000FF; cpal_mem[3] = 24'h123456;

        // R1 reset state
        @(posedge clk); #5;
        check(out_valid == 1'b0, "R1 reset valid", {23'h0, out_valid}, 24'h0);
        check(out_rgb == 24'h0, "R1 reset rgb", out_rgb, 24'h0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < 17; i++) begin
            drive(1'b1, VECS[i].x, VECS[i].y, VECS[i].idx, VECS[i].pos, VECS[i].blank, VECS[i].off);
            check(out_valid == 1'b1, "R1 valid", {23'h0, out_valid}, 24'h1);
            check(out_rgb == expect_rgb(VECS[i].src, VECS[i].idx),
                  $sformatf("R2-R9 vector %0d", i), out_rgb, expect_rgb(VECS[i].src, VECS[i].idx));
        end

        // R10 hold on idle cycle, R1 valid drops
        held = out_rgb;
        drive(1'b0, 12'd300, 12'd300, 8'd77, P0, 1'b0, 1'b0);
        check(out_valid == 1'b0, "R1 idle", {23'h0, out_valid}, 24'h0);
        check(out_rgb == held, "R10 hold", out_rgb, held);

        // R10 hold even when blank asserted on idle cycle
        drive(1'b0, 12'd300, 12'd300, 8'd77, P0, 1'b1, 1'b0);
        check(out_rgb == held, "R10 hold blank", out_rgb, held);

        // R6 with a fresh pointer colour value
        cpal_mem[1] = 24'hABCDEF;
        drive(1'b1, 12'd101, 12'd50, 8'd7, P0, 1'b0, 1'b0);
        check(out_rgb == 24'hABCDEF, "R6 colour 1", out_rgb, 24'hABCDEF);

        // R1 reset mid-stream
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b1;
        @(posedge clk); #5;
        check(out_rgb == 24'h0 && out_valid == 1'b0, "R1 reset again", out_rgb, 24'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule